// File: doc/BRIEF.md
# Cycle/Scanline IRQ Timer

This block raises an interrupt after a programmable number of CPU cycles or of approximate video scanlines. An 8-bit counter counts upward from a value held in an 8-bit reload latch. When the counter steps past 0xFF it reloads from the latch and raises the interrupt line. The line stays high until software clears it. In scanline mode, a signed prescaler stands in for the horizontal timing. It loses 3 on every CPU cycle and gains 341 each time it reaches zero or goes below zero. The counter therefore advances once per 114, 114 and 113 cycles in turn, or 341/3 cycles on average. In cycle mode the counter advances on every CPU cycle.

Software reaches the block through a single write port with a 2-bit select and a 4-bit data field. Two selects fill the latch one nibble at a time. The third select writes the control bits, and the fourth acknowledges the interrupt. The outer register decode is left to the surrounding logic. A small state machine keeps the run state. ST_OFF means the counter is frozen. ST_LINE means it counts through the prescaler. ST_CYCLE means it counts directly. A control write moves the machine to ST_OFF when the enable bit is clear. When the enable bit is set, it moves to ST_CYCLE if the cycle bit is set and to ST_LINE if that bit is clear. An acknowledge write takes the same decision, using the stored re-arm bit in place of the enable bit and the stored cycle bit. Every other cycle keeps the current state.

Top module: `cyc_line_timer`

## Requirements
- R1: After reset `irq` is low, and the latch, the counter, the control bits and the prescaler are all zero. As a result, enabling cycle mode without writing the latch first gives the first interrupt after 256 ticks.
- R2: A write with `wr_sel`=0 loads `wr_data` into latch bits 3:0. A write with `wr_sel`=1 loads `wr_data` into latch bits 7:4. Each of these writes leaves the other nibble unchanged.
- R3: A write with `wr_sel`=2 stores the control bits: bit 0 is re-arm, bit 1 is enable and bit 2 is cycle mode. The write always drives `irq` low. If bit 1 is set, the write also loads the counter from the latch and sets the prescaler to 341.
- R4: A write with `wr_sel`=3 drives `irq` low. It also copies the stored re-arm bit into the enable bit and does not touch the counter or the prescaler.
- R5: In cycle mode (enable and cycle bits both set) the counter advances by one on each `cpu_tick`.
- R6: In scanline mode (enable set, cycle bit clear), each `cpu_tick` subtracts 3 from the prescaler. If the result is zero or negative, 341 is added to it and the counter advances. Starting from a control write, the interrupts therefore come 114, 114 and 113 ticks apart.
- R7: When the counter advances from 0xFF, it reloads from the latch and `irq` goes high. `irq` then stays high until a control or acknowledge write.
- R8: While enable is clear, `cpu_tick` changes neither the counter nor the prescaler.
- R9: A control or acknowledge write in the same cycle as `cpu_tick` takes priority, and that tick is discarded.
- R10: A latch write does not change a running count. The new latch value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_tick | input | 1 | One-cycle strobe per CPU cycle |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select: 0 latch low, 1 latch high, 2 control, 3 acknowledge |
| wr_data | input | 4 | Write data nibble |
| irq | output | 1 | Interrupt request, level held |

## Verification
Two functions can fall in the same cycle: a counter advance and a control or acknowledge write. The bench provokes this by sending an acknowledge in the same cycle as a tick, at a point where the counter sits two steps before overflow. It then judges from the timing of the next interrupt whether that tick was discarded: the interrupt must arrive after exactly two further ticks, not one. A second collision comes from a counter overflow on the cycle right after a clear, and the bench checks that the held level follows the overflow.

// File: rtl/clt_pkg.sv
package clt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_LINE  = 2'd1,
        ST_CYCLE = 2'd2
    } run_state_t;

    localparam int BIT_REARM = 0;
    localparam int BIT_EN    = 1;
    localparam int BIT_CYC   = 2;
    localparam int CTL_W     = 3;

endpackage

// File: rtl/clt_latch.sv
module clt_latch #(
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 2,
    parameter int SEL_W   = 2,
    localparam int LAT_W  = NIB_W * NUM_NIB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NIB_W-1:0] wr_data,
    output logic [LAT_W-1:0] latch_o
);

    for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
        logic [NIB_W-1:0] nib_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                nib_q <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                nib_q <= wr_data;
            end
        end

        assign latch_o[g*NIB_W +: NIB_W] = nib_q;
    end

endmodule

// File: rtl/clt_prescale.sv
module clt_prescale #(
    parameter int PRE_W      = 10,
    parameter int PRE_RELOAD = 341,
    parameter int PRE_STEP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic step_o
);

    localparam logic signed [PRE_W-1:0] RELOAD_S = PRE_RELOAD[PRE_W-1:0];
    localparam logic signed [PRE_W-1:0] STEP_S   = PRE_STEP[PRE_W-1:0];

    logic signed [PRE_W-1:0] pre_q;
    logic signed [PRE_W-1:0] diff;
    logic                    expired;

    always_comb begin
        diff    = pre_q - STEP_S;
        expired = diff[PRE_W-1] || (diff == '0);
        step_o  = run_i && expired;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (load_i) begin
            pre_q <= RELOAD_S;
        end else if (run_i) begin
            pre_q <= expired ? (diff + RELOAD_S) : diff;
        end
    end

endmodule

// File: rtl/clt_count.sv
module clt_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] latch_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap_o  = step_i && (&cnt_q);
    assign count_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i || wrap_o) begin
            cnt_q <= latch_i;
        end else if (step_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/clt_ctrl.sv
module clt_ctrl
    import clt_pkg::*;
#(
    parameter int SEL_W   = 2,
    parameter int NUM_NIB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_tick,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CTL_W-1:0] ctl_data,
    input  logic             wrap_i,
    output run_state_t       state_o,
    output logic             load_o,
    output logic             adv_o,
    output logic             irq_o
);

    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(NUM_NIB);
    localparam logic [SEL_W-1:0] SEL_ACK  = SEL_W'(NUM_NIB + 1);

    run_state_t state_q, state_d;
    logic       rearm_q, cyc_q;
    logic       wr_ctrl, wr_ack;

    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    assign wr_ack  = wr_en && (wr_sel == SEL_ACK);
    assign load_o  = wr_ctrl && ctl_data[BIT_EN];
    assign adv_o   = cpu_tick && !wr_ctrl && !wr_ack && (state_q != ST_OFF);
    assign state_o = state_q;

    always_comb begin
        state_d = state_q;
        unique case (1'b1)
            wr_ctrl: begin
                if (!ctl_data[BIT_EN])       state_d = ST_OFF;
                else if (ctl_data[BIT_CYC])  state_d = ST_CYCLE;
                else                         state_d = ST_LINE;
            end
            wr_ack: begin
                if (!rearm_q)                state_d = ST_OFF;
                else if (cyc_q)              state_d = ST_CYCLE;
                else                         state_d = ST_LINE;
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            rearm_q <= 1'b0;
            cyc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_ctrl) begin
                rearm_q <= ctl_data[BIT_REARM];
                cyc_q   <= ctl_data[BIT_CYC];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (wr_ctrl || wr_ack) begin
            irq_o <= 1'b0;
        end else if (wrap_i) begin
            irq_o <= 1'b1;
        end
    end

endmodule

// File: rtl/cyc_line_timer.sv
module cyc_line_timer
    import clt_pkg::*;
#(
    parameter int NIB_W      = 4,
    parameter int PRE_W      = 10,
    parameter int PRE_RELOAD = 341,
    parameter int PRE_STEP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [NIB_W-1:0] wr_data,
    output logic             irq
);

    localparam int NUM_NIB = 2;
    localparam int SEL_W   = 2;
    localparam int LAT_W   = NIB_W * NUM_NIB;

    run_state_t       run_state;
    logic [LAT_W-1:0] latch_val;
    logic [LAT_W-1:0] count_val;
    logic             load, adv, wrap, line_step, cnt_step, run_line;

    clt_latch #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .SEL_W(SEL_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .latch_o (latch_val)
    );

    clt_ctrl #(.SEL_W(SEL_W), .NUM_NIB(NUM_NIB)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_tick (cpu_tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .ctl_data (wr_data[CTL_W-1:0]),
        .wrap_i   (wrap),
        .state_o  (run_state),
        .load_o   (load),
        .adv_o    (adv),
        .irq_o    (irq)
    );

    assign run_line = adv && (run_state == ST_LINE);
    assign cnt_step = (run_state == ST_CYCLE) ? adv : line_step;

    clt_prescale #(.PRE_W(PRE_W), .PRE_RELOAD(PRE_RELOAD), .PRE_STEP(PRE_STEP)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .run_i  (run_line),
        .step_o (line_step)
    );

    clt_count #(.CNT_W(LAT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (cnt_step),
        .latch_i (latch_val),
        .count_o (count_val),
        .wrap_o  (wrap)
    );

endmodule

// File: rtl/clt_checker.sv
module clt_checker
    import clt_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_tick,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [NIB_W-1:0] wr_data,
    input logic             irq,
    input run_state_t       run_state,
    input logic [CNT_W-1:0] count_val,
    input logic [CNT_W-1:0] latch_val
);

    logic clr_wr;
    assign clr_wr = wr_en && wr_sel[1];

    AST_CTL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> !irq); // R3

    AST_CTL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && wr_data[BIT_EN]) |=> (count_val == $past(latch_val))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> !irq); // R4

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_CYCLE && cpu_tick && !clr_wr && !(&count_val))
        |=> (count_val == $past(count_val) + CNT_W'(1))); // R5

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq); // R7

    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cpu_tick)); // R7

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_OFF && !clr_wr) |=> $stable(count_val)); // R8

    AST_COLLIDE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tick && clr_wr && !(wr_sel == 2'd2 && wr_data[BIT_EN])) |=> $stable(count_val)); // R9

endmodule

bind cyc_line_timer clt_checker #(.NIB_W(NIB_W), .CNT_W(LAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_tick  (cpu_tick),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .irq       (irq),
    .run_state (run_state),
    .count_val (count_val),
    .latch_val (latch_val)
);

// File: tb/sim_cyc_line_timer.sv
`timescale 1ns/1ps
module sim_cyc_line_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [3:0] wr_data = 4'd0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    string q_req[$];
    logic  q_exp[$];

    always #4 clk = ~clk;

    cyc_line_timer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_tick (cpu_tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .irq      (irq)
    );

    // Monitor: pops expected items and compares against the port.
    always @(negedge clk) begin
        while (q_exp.size() > 0) begin
            string r;
            logic  e;
            r = q_req.pop_front();
            e = q_exp.pop_front();
            n_chk++;
            if (irq !== e) begin
                n_fail++;
                $display("FAIL %s irq=%0b expected=%0b at %0t", r, irq, e, $time);
            end
        end
    end

    task automatic expect_irq(input string r, input logic e);
        q_req.push_back(r);
        q_exp.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic cyc(input logic t, input logic we, input logic [1:0] s, input logic [3:0] d);
        cpu_tick = t;
        wr_en    = we;
        wr_sel   = s;
        wr_data  = d;
        @(posedge clk);
        #1;
        cpu_tick = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 4'd0);
    endtask

    // Interrupt must be low after n-1 ticks and high after the n-th.
    task automatic period(input int n, input string r);
        if (n > 1) ticks(n - 1);
        expect_irq(r, 1'b0);
        ticks(1);
        expect_irq(r, 1'b1);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_irq("R1", 1'b0);

        // R1: zero latch -> 256 ticks in cycle mode
        cyc(1'b0, 1'b1, 2'd2, 4'h6);
        period(256, "R1");
        ticks(3);
        expect_irq("R7", 1'b1);            // R7 level held

        // R4: ack clears; re-arm was 0 so the timer stops
        cyc(1'b0, 1'b1, 2'd3, 4'h0);
        expect_irq("R4", 1'b0);
        ticks(300);
        expect_irq("R8", 1'b0);

        // R2: latch = 0xFE via two nibbles
        cyc(1'b0, 1'b1, 2'd0, 4'hE);
        cyc(1'b0, 1'b1, 2'd1, 4'hF);
        cyc(1'b0, 1'b1, 2'd2, 4'h6);
        ticks(1);
        expect_irq("R2", 1'b0);            // count now 0xFF
        cyc(1'b0, 1'b1, 2'd2, 4'h5);       // disable, keep count, re-arm
        ticks(50);
        expect_irq("R8", 1'b0);
        cyc(1'b0, 1'b1, 2'd3, 4'h0);       // ack re-enables from re-arm bit
        ticks(1);
        expect_irq("R4", 1'b1);            // R8 count was frozen at 0xFF

        // R7: reload from latch 0xFE -> period of 2
        cyc(1'b0, 1'b1, 2'd3, 4'h0);
        period(2, "R7");

        // R9: ack and tick in one cycle, tick discarded
        cyc(1'b1, 1'b1, 2'd3, 4'h0);
        expect_irq("R9", 1'b0);
        ticks(1);
        expect_irq("R9", 1'b0);
        ticks(1);
        expect_irq("R9", 1'b1);

        // R6: scanline mode, latch 0xFF
        cyc(1'b0, 1'b1, 2'd0, 4'hF);
        cyc(1'b0, 1'b1, 2'd2, 4'h3);
        expect_irq("R3", 1'b0);
        period(114, "R6");
        cyc(1'b0, 1'b1, 2'd3, 4'h0);
        period(114, "R6");
        cyc(1'b0, 1'b1, 2'd3, 4'h0);
        period(113, "R6");

        // R3: control write clears irq and disables
        cyc(1'b0, 1'b1, 2'd2, 4'h0);
        expect_irq("R3", 1'b0);
        ticks(300);
        expect_irq("R8", 1'b0);

        // R10: latch write while running does not touch the count
        cyc(1'b0, 1'b1, 2'd2, 4'h7);       // count 0xFF, cycle mode
        cyc(1'b0, 1'b1, 2'd0, 4'h0);
        cyc(1'b0, 1'b1, 2'd1, 4'h0);       // latch 0x00
        ticks(1);
        expect_irq("R10", 1'b1);
        cyc(1'b0, 1'b1, 2'd3, 4'h0);
        period(256, "R10");

        // R3: enable reloads count from latch 0xFD
        cyc(1'b0, 1'b1, 2'd0, 4'hD);
        cyc(1'b0, 1'b1, 2'd1, 4'hF);
        cyc(1'b0, 1'b1, 2'd2, 4'h6);
        expect_irq("R3", 1'b0);
        period(3, "R3");

        // R5: cycle mode advances one per tick (0xFD -> period 3 again)
        cyc(1'b0, 1'b1, 2'd2, 4'h6);
        ticks(2);
        expect_irq("R5", 1'b0);
        ticks(1);
        expect_irq("R5", 1'b1);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule